// File: doc/BRIEF.md
# Threshold Edge Trigger Window Recorder

This block watches a stream of signed 16-bit converter samples, one sample per clock. It raises a one-cycle trigger flag when the signal crosses a programmable level in the selected direction. A crossing is found by comparing the new sample and the sample before it against the level. Each trigger opens a capture window. The window starts a programmable number of samples before the crossing, so that the lead-in of the pulse is kept, and it runs a programmable number of samples after it. A trigger that arrives while a window is still open stretches that window. The result is one longer window and not two windows that overlap.

The kept samples leave the block on two streams. One is a per-sample stream with a start-of-window marker. The other is a packed stream of 64-bit words, each holding four samples. The pre-trigger samples come from a circular history of the last 16 samples, which delays the per-sample stream by the precursor setting. A window that ends part way through a word sends that word out padded with zeros, together with a count of the valid samples in it. The configuration inputs are expected to stay constant while data flows.

Top module: `edge_window_recorder`

## Requirements
- R1: With `falling` = 0, `trig_flag` is high in the cycle after sample s[k] is presented exactly when s[k-1] < `threshold` and s[k] >= `threshold`, compared as signed numbers.
- R2: With `falling` = 1, `trig_flag` is high in the cycle after s[k] exactly when s[k-1] >= `threshold` and s[k] < `threshold`, compared as signed numbers.
- R3: The first sample presented after reset never raises `trig_flag`, because it has no predecessor.
- R4: For precursor P and length L, a crossing found at sample n keeps samples n-P through n+L, which is P+L+1 samples in all (19 for P=6, L=12). Sample s[m] appears on `win_sample` with `win_valid` high P+1 cycles after it was presented. The samples keep their input order.
- R5: A sample is kept when any crossing n satisfies m-L <= n <= m+P. A crossing inside an open window therefore extends that window to the new n+L, and windows that touch or overlap merge into one.
- R6: `win_sop` is high together with `win_valid` on the first sample of each window only.
- R7: Only samples presented since the last reset are emitted. When a crossing comes less than P samples after reset, the precursor part of its window is cut short. P may be any value from 0 to 16.
- R8: Kept samples are packed four to a word in order, with the first sample in bits [15:0] and the fourth in bits [63:48]. A full word appears with `word_valid` high and `word_count` = 4 one cycle after its fourth sample appears on `win_sample`. `word_first` marks the word that holds a window's first sample.
- R9: When a window ends with 1 to 3 samples in an open word, that word appears two cycles after its last sample appears on `win_sample`. `word_count` gives the number of valid samples, and the unused upper lanes read zero.
- R10: A synchronous active-high `rst` clears the history, any window in progress and any partly filled word. While `rst` is high and in the first cycle after it falls, `trig_flag`, `win_valid` and `word_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | 16 | Signed input sample |
| threshold | input | 16 | Signed trigger level |
| falling | input | 1 | 0 selects a rising crossing, 1 a falling one |
| precursor | input | 5 | Samples kept before the crossing, 0 to 16 |
| post_len | input | 8 | Samples kept after the crossing |
| trig_flag | output | 1 | One-cycle crossing flag |
| win_valid | output | 1 | A kept sample is on win_sample |
| win_sop | output | 1 | First sample of a window |
| win_sample | output | 16 | Kept sample, delayed by the precursor |
| word_valid | output | 1 | A packed word is on word_data |
| word_first | output | 1 | This word holds a window's first sample |
| word_count | output | 3 | Valid samples in the word, 1 to 4 |
| word_data | output | 64 | Four packed samples, lane 0 lowest |

## Verification
The properties check on every cycle that each trigger flag is backed by a real crossing of the level in the chosen direction, using the sample values two and one cycles earlier. They also check that a trigger seen with a filled history always puts its sample on the window stream, that a start marker only opens a new window, that word counts stay between one and four with zero padding above the count, and that every output is quiet just after reset. Which samples fall inside a window, how windows merge when they are extended, how the precursor is cut short after reset, and the exact cycle at which each word appears are checked only by the bench. The bench sweeps precursor, length, polarity and signal shape, and compares every output cycle against a model computed from the requirements.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int SAMPLE_W = 16;
  typedef logic signed [SAMPLE_W-1:0] sample_t;

  // Crossing rule shared by the trigger unit; the bench restates it by hand.
  function automatic logic crossed(input sample_t prev, input sample_t cur,
                                   input sample_t level, input logic fall);
    if (fall) return (prev >= level) && (cur < level);
    else      return (prev < level) && (cur >= level);
  endfunction
endpackage

// File: rtl/tw_history.sv
module tw_history
  import tw_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  sample_t       din,
  input  logic [PW-1:0] lag,
  output sample_t       dout,
  output logic          ready
);
  sample_t       ring [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [PW-1:0] fill;

  // lag == DEPTH wraps to the slot about to be overwritten, which holds
  // the oldest sample; DEPTH must be a power of two.
  assign dout  = (lag == '0) ? din : ring[wr_ptr - lag[AW-1:0]];
  assign ready = (fill >= lag);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      fill   <= '0;
      for (int i = 0; i < DEPTH; i++) ring[i] <= '0;
    end else begin
      ring[wr_ptr] <= din;
      wr_ptr       <= wr_ptr + AW'(1);
      if (fill < PW'(DEPTH)) fill <= fill + PW'(1);
    end
  end
endmodule

// File: rtl/tw_window.sv
module tw_window
  import tw_pkg::*;
#(
  parameter int PW = 5,
  parameter int LW = 8,
  localparam int CW = ((PW > LW) ? PW : LW) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  sample_t       sample,
  input  sample_t       level,
  input  logic          fall,
  input  logic [PW-1:0] lag,
  input  logic [LW-1:0] post_len,
  input  logic          ready,
  output logic          edge_hit,
  output logic          keep
);
  sample_t       prev;
  logic          prev_ok;
  logic [CW-1:0] remain;
  logic [CW-1:0] span;

  assign span     = CW'(lag) + CW'(post_len);
  assign edge_hit = prev_ok && crossed(prev, sample, level, fall);
  // Output runs lag cycles behind the input, so a window stays open for
  // lag + post_len cycles after the crossing cycle.
  assign keep     = (edge_hit || (remain != '0)) && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev    <= '0;
      prev_ok <= 1'b0;
      remain  <= '0;
    end else begin
      prev    <= sample;
      prev_ok <= 1'b1;
      if (edge_hit)            remain <= span;
      else if (remain != '0)   remain <= remain - CW'(1);
    end
  end
endmodule

// File: rtl/tw_packer.sv
module tw_packer
  import tw_pkg::*;
#(
  parameter int LANES = 4,
  localparam int IW = $clog2(LANES),
  localparam int CNTW = $clog2(LANES + 1),
  localparam int WW = LANES * SAMPLE_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            in_sop,
  input  sample_t         in_sample,
  output logic            word_valid,
  output logic            word_first,
  output logic [CNTW-1:0] word_count,
  output logic [WW-1:0]   word_data
);
  sample_t       lanes   [LANES];
  sample_t       lanes_n [LANES];
  logic [IW-1:0] idx;
  logic          first_pend;
  logic          full_hit;
  logic          flush_hit;
  logic [WW-1:0] packed_n;

  always_comb begin
    for (int k = 0; k < LANES; k++) lanes_n[k] = lanes[k];
    if (in_valid) lanes_n[idx] = in_sample;
    for (int k = 0; k < LANES; k++) packed_n[k*SAMPLE_W +: SAMPLE_W] = lanes_n[k];
  end

  assign full_hit  = in_valid && (idx == IW'(LANES - 1));
  assign flush_hit = !in_valid && (idx != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx        <= '0;
      first_pend <= 1'b0;
      word_valid <= 1'b0;
      word_first <= 1'b0;
      word_count <= '0;
      word_data  <= '0;
      for (int k = 0; k < LANES; k++) lanes[k] <= '0;
    end else begin
      word_valid <= full_hit || flush_hit;
      if (full_hit || flush_hit) begin
        word_data  <= packed_n;
        word_count <= in_valid ? CNTW'(LANES) : CNTW'(idx);
        word_first <= first_pend || (in_valid && in_sop);
        idx        <= '0;
        first_pend <= 1'b0;
        for (int k = 0; k < LANES; k++) lanes[k] <= '0;
      end else begin
        for (int k = 0; k < LANES; k++) lanes[k] <= lanes_n[k];
        if (in_valid) idx <= idx + IW'(1);
        first_pend <= first_pend || (in_valid && in_sop);
      end
    end
  end
endmodule

// File: rtl/edge_window_recorder.sv
module edge_window_recorder
  import tw_pkg::*;
#(
  parameter int HIST_DEPTH = 16,
  parameter int LEN_W = 8,
  parameter int LANES = 4,
  localparam int PW = $clog2(HIST_DEPTH + 1),
  localparam int CNTW = $clog2(LANES + 1),
  localparam int WW = LANES * SAMPLE_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [SAMPLE_W-1:0] sample_in,
  input  logic signed [SAMPLE_W-1:0] threshold,
  input  logic                       falling,
  input  logic [PW-1:0]              precursor,
  input  logic [LEN_W-1:0]           post_len,
  output logic                       trig_flag,
  output logic                       win_valid,
  output logic                       win_sop,
  output logic signed [SAMPLE_W-1:0] win_sample,
  output logic                       word_valid,
  output logic                       word_first,
  output logic [CNTW-1:0]            word_count,
  output logic [WW-1:0]              word_data
);
  sample_t hist_dout;
  logic    hist_ready;
  logic    edge_hit;
  logic    keep;

  tw_history #(.DEPTH(HIST_DEPTH)) u_hist (
    .clk(clk), .rst(rst), .din(sample_in), .lag(precursor),
    .dout(hist_dout), .ready(hist_ready)
  );

  tw_window #(.PW(PW), .LW(LEN_W)) u_win (
    .clk(clk), .rst(rst), .sample(sample_in), .level(threshold),
    .fall(falling), .lag(precursor), .post_len(post_len),
    .ready(hist_ready), .edge_hit(edge_hit), .keep(keep)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_flag  <= 1'b0;
      win_valid  <= 1'b0;
      win_sop    <= 1'b0;
      win_sample <= '0;
    end else begin
      trig_flag  <= edge_hit;
      win_valid  <= keep;
      win_sop    <= keep && !win_valid;
      win_sample <= keep ? hist_dout : '0;
    end
  end

  tw_packer #(.LANES(LANES)) u_pack (
    .clk(clk), .rst(rst), .in_valid(win_valid), .in_sop(win_sop),
    .in_sample(win_sample), .word_valid(word_valid), .word_first(word_first),
    .word_count(word_count), .word_data(word_data)
  );
endmodule

// File: rtl/tw_checker.sv
module tw_checker #(
  parameter int SW = 16,
  parameter int LANES = 4,
  parameter int CNTW = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic signed [SW-1:0] sample_in,
  input logic signed [SW-1:0] threshold,
  input logic                 falling,
  input logic                 trig_flag,
  input logic                 win_valid,
  input logic                 win_sop,
  input logic                 word_valid,
  input logic [CNTW-1:0]      word_count,
  input logic [LANES*SW-1:0]  word_data,
  input logic                 hist_ready
);
  p_rise_r1: assert property (@(posedge clk) disable iff (rst)
    (trig_flag && !$past(falling)) |->
      ($past(sample_in, 2) < $past(threshold) && $past(sample_in) >= $past(threshold)));

  p_fall_r2: assert property (@(posedge clk) disable iff (rst)
    (trig_flag && $past(falling)) |->
      ($past(sample_in, 2) >= $past(threshold) && $past(sample_in) < $past(threshold)));

  p_trig_kept_r4: assert property (@(posedge clk) disable iff (rst)
    (trig_flag && $past(hist_ready)) |-> win_valid);

  p_sop_opens_r6: assert property (@(posedge clk) disable iff (rst)
    win_sop |-> (win_valid && !$past(win_valid)));

  p_count_range_r9: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> (word_count >= CNTW'(1) && word_count <= CNTW'(LANES)));

  p_pad_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (word_valid && word_count < CNTW'(LANES)) |->
      ((word_data >> (int'(word_count) * SW)) == '0));

  p_quiet_after_reset_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!trig_flag && !win_valid && !word_valid));
endmodule

bind edge_window_recorder tw_checker #(
  .SW(tw_pkg::SAMPLE_W), .LANES(LANES), .CNTW(CNTW)
) u_chk (
  .clk(clk), .rst(rst), .sample_in(sample_in), .threshold(threshold),
  .falling(falling), .trig_flag(trig_flag), .win_valid(win_valid),
  .win_sop(win_sop), .word_valid(word_valid), .word_count(word_count),
  .word_data(word_data), .hist_ready(hist_ready)
);

// File: tb/edge_window_recorder_test.sv
module edge_window_recorder_test;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic signed [15:0] sample_in = '0;
  logic signed [15:0] threshold = '0;
  logic               falling = 1'b0;
  logic [4:0]         precursor = '0;
  logic [7:0]         post_len = '0;
  logic               trig_flag, win_valid, win_sop, word_valid, word_first;
  logic signed [15:0] win_sample;
  logic [2:0]         word_count;
  logic [63:0]        word_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic signed [15:0] s  [256];
  bit                 e  [256];
  bit                 kp [256];
  logic [63:0] ew_data [64]; int ew_cnt [64]; int ew_t [64]; bit ew_first [64];
  logic [63:0] ow_data [64]; int ow_cnt [64]; int ow_t [64]; bit ow_first [64];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  edge_window_recorder uut (
    .clk(clk), .rst(rst), .sample_in(sample_in), .threshold(threshold),
    .falling(falling), .precursor(precursor), .post_len(post_len),
    .trig_flag(trig_flag), .win_valid(win_valid), .win_sop(win_sop),
    .win_sample(win_sample), .word_valid(word_valid), .word_first(word_first),
    .word_count(word_count), .word_data(word_data)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run_cfg(input int p, input int l, input bit fl, input int pat);
    int n, tt, nw_exp, nw_obs, lane, wins;
    string wtag;
    n = 64;
    tt = n + p + l + 6;
    wtag = (p == 16) ? "R7" : ((pat == 3) ? "R5" : "R4");
    threshold = (pat == 0) ? -16'sd37 : ((pat == 1) ? 16'sd200 : 16'sd0);
    for (int k = 0; k < tt; k++) begin
      if (k >= n) s[k] = s[n-1];
      else begin
        case (pat)
          0: begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            s[k] = $signed(lfsr) >>> 6;
          end
          1: s[k] = 16'((((k % 24) < 12) ? (k % 24) : (24 - (k % 24))) * 200 - 1200);
          2: s[k] = (k == 0 || (k >= 20 && k <= 23)) ? 16'sd1000 : -16'sd1000;
          default: s[k] = ((k >= 10 && k <= 11) || (k >= 19 && k <= 20)) ? 16'sd1000 : -16'sd1000;
        endcase
      end
    end
    e[0] = 0;
    for (int k = 1; k < tt; k++)
      e[k] = fl ? (s[k-1] >= threshold && s[k] < threshold)
                : (s[k-1] < threshold && s[k] >= threshold);
    for (int m = 0; m < tt; m++) begin
      kp[m] = 0;
      for (int j = m - l; j <= m + p; j++)
        if (j >= 0 && j < tt && e[j]) kp[m] = 1;
    end
    nw_exp = 0; lane = 0;
    for (int m = 0; m < tt; m++) begin
      if (kp[m]) begin
        if (lane == 0) begin
          ew_data[nw_exp] = '0;
          ew_first[nw_exp] = (m == 0) || !kp[m-1];
        end
        ew_data[nw_exp][lane*16 +: 16] = s[m];
        lane++;
        if (lane == 4) begin
          ew_cnt[nw_exp] = 4; ew_t[nw_exp] = m + p + 1; nw_exp++; lane = 0;
        end
      end else if (lane > 0) begin
        ew_cnt[nw_exp] = lane; ew_t[nw_exp] = m - 1 + p + 2; nw_exp++; lane = 0;
      end
    end
    falling = fl; precursor = 5'(p); post_len = 8'(l);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(!trig_flag && !win_valid && !word_valid, "R10", "outputs in reset",
          {trig_flag, win_valid, word_valid}, 0);
    @(negedge clk);
    rst = 1'b0;
    nw_obs = 0; wins = 0;
    for (int k = 0; k < tt; k++) begin
      bit expv;
      int m;
      sample_in = s[k];
      @(posedge clk);
      #1;
      check(trig_flag == e[k], (k == 0) ? "R3" : (fl ? "R2" : "R1"), "trig_flag",
            trig_flag, e[k]);
      m = k - p;
      expv = (m >= 0) && kp[m];
      check(win_valid == expv, wtag, "win_valid", win_valid, expv);
      if (win_valid && expv) begin
        wins++;
        check(win_sample == s[m], wtag, "win_sample", win_sample, s[m]);
        check(win_sop == ((m == 0) || !kp[m-1]), "R6", "win_sop", win_sop,
              (m == 0) || !kp[m-1]);
      end
      if (word_valid && nw_obs < 64) begin
        ow_data[nw_obs] = word_data; ow_cnt[nw_obs] = word_count;
        ow_t[nw_obs] = k; ow_first[nw_obs] = word_first; nw_obs++;
      end
      @(negedge clk);
    end
    if (p == 6 && l == 12 && pat == 2 && !fl)
      check(wins == 19, "R4", "single window length", wins, 19);
    check(nw_obs == nw_exp, "R8", "word count", nw_obs, nw_exp);
    for (int w = 0; w < nw_exp && w < nw_obs; w++) begin
      string t;
      t = (ew_cnt[w] == 4) ? "R8" : "R9";
      check(ow_data[w] == ew_data[w], t, "word_data", ow_data[w], ew_data[w]);
      check(ow_cnt[w] == ew_cnt[w], t, "word_count", ow_cnt[w], ew_cnt[w]);
      check(ow_t[w] == ew_t[w], t, "word cycle", ow_t[w], ew_t[w]);
      check(ow_first[w] == ew_first[w], "R8", "word_first", ow_first[w], ew_first[w]);
    end
  endtask

  task automatic reset_mid_window();
    threshold = 16'sd0; falling = 1'b0; precursor = 5'd6; post_len = 8'd12;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 26; k++) begin
      sample_in = (k >= 20) ? 16'sd1000 : -16'sd1000;
      @(negedge clk);
    end
    rst = 1'b1;
    sample_in = -16'sd1000;
    repeat (2) begin
      @(posedge clk);
      #1;
      check(!win_valid && !word_valid && !trig_flag, "R10", "outputs during reset",
            {trig_flag, win_valid, word_valid}, 0);
    end
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 30; k++) begin
      @(posedge clk);
      #1;
      check(!win_valid && !word_valid && !trig_flag, "R10", "window dropped after reset",
            {trig_flag, win_valid, word_valid}, 0);
    end
  endtask

  initial begin
    int plist [5] = '{0, 1, 3, 6, 16};
    int llist [3] = '{0, 2, 12};
    for (int pi = 0; pi < 5; pi++)
      for (int li = 0; li < 3; li++)
        for (int f = 0; f < 2; f++)
          for (int pat = 0; pat < 4; pat++)
            run_cfg(plist[pi], llist[li], f[0], pat);
    reset_mid_window();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule